// File: doc/BRIEF.md
# Transmit Frame Fetch and Pad Engine

This block sits between a shared byte-wide packet memory and the transmit side of a MAC. The host first places a frame in memory. One control byte goes first, and the frame data follows it. The host then gives the block two pointers and pulses a request. The block reads the control byte at the start pointer and decides the effective padding, CRC and oversize settings. It then streams the frame bytes from start+1 through the end pointer, inclusive, on a valid/ready byte stream. When padding applies, it appends zero bytes to reach the minimum frame size.

When the frame is finished or refused, the block writes a seven-byte status record into memory. The record starts at the address just after the last frame byte. The block then drops its busy bit and raises a sticky done flag. A programmable gap timer holds off the next frame for a set number of cycles after completion. CRC generation itself is done further down the path. This block only drives a sideband that says whether a CRC must be appended.

The memory read port is combinational toward a synchronous RAM with one cycle of read latency. The write port, the stream outputs and all flags are registered. Pointer arithmetic wraps modulo the memory size.

Top module: `tx_frame_fetch`

## Requirements
- R1: After reset, req_busy, done_flag, abort_flag, out_valid and mem_wr_en are all 0.
- R2: A req_set pulse while idle sets req_busy. req_busy stays 1 until the frame and its status record are complete. It falls in the same cycle that done_flag rises, and done_flag then holds until done_clr.
- R3: The byte at the start pointer is the control byte and is never streamed. The frame data is the bytes at start+1 through end, in address order, wrapping modulo 2^AW. out_last marks only the final byte of the frame.
- R4: Control byte bit 0 selects the source of the settings. When bit 0 is 0, the cfg_pad_en, cfg_crc_en and cfg_huge_en inputs apply. When bit 0 is 1, bit 1 enables CRC, bit 2 enables padding and bit 3 allows oversize frames. So 0x00 uses the global settings, and 0x0B gives CRC on, oversize allowed and padding off.
- R5: With padding in effect, a frame of fewer than MIN_LEN data bytes is extended with 0x00 bytes to exactly MIN_LEN bytes.
- R6: A frame with more than MAX_LEN data bytes is refused unless oversize is allowed. A refused frame streams no bytes, and abort_flag is 1 after done. A frame that completes clears abort_flag at its done.
- R7: Exactly seven bytes are written at end+1 through end+7. Byte 0 is the sent byte count, low byte. Byte 1 is the count, high byte. Byte 2 carries bit 7 = completed without abort and bit 0 = CRC in effect, with all other bits 0. Bytes 3 to 6 are 0x00.
- R8: out_crc_en equals the effective CRC setting on every byte of the frame.
- R9: After done, the next frame's first byte is not valid until at least ipg_len+3 cycles later.
- R10: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold.
- R11: A frame with no data bytes and no padding streams nothing. Its status shows a count of 0 with bit 7 of byte 2 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set | input | 1 | Pulse that starts a transmission when idle |
| done_clr | input | 1 | Clears done_flag |
| start_ptr | input | AW | Address of the control byte, latched on req_set |
| end_ptr | input | AW | Address of the last frame byte, latched on req_set |
| cfg_pad_en | input | 1 | Global automatic padding enable |
| cfg_crc_en | input | 1 | Global CRC append enable |
| cfg_huge_en | input | 1 | Global oversize frame allow |
| ipg_len | input | GW | Gap cycles enforced after each done |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | 8 | Read data, one cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe for the status record |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | 8 | Memory write data |
| out_data | output | 8 | Stream byte |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_last | output | 1 | Final byte of the frame |
| out_crc_en | output | 1 | CRC must be appended to this frame |
| req_busy | output | 1 | Transmit request bit |
| done_flag | output | 1 | Sticky transmit-done flag |
| abort_flag | output | 1 | Last frame was refused |

## Verification
The assertions assume three things. Read data arrives exactly one cycle after a read strobe. The memory regions that hold the frame and its status record do not overlap other live data. req_set is only pulsed when the pointers are meaningful. The bench supplies a one-cycle-latency memory model and writes each frame and a guard pattern before every request. It pulses req_set only when idle or exactly as done is seen. A pseudo-random out_ready pattern exercises the hold behaviour under backpressure, while the back-to-back gap measurements run with out_ready held high.

// File: rtl/txf_pkg.sv
package txf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_LOAD, ST_SEND, ST_STAT, ST_DONE
  } txf_state_e;

  // control byte bit positions (decoded by tx_ctrl_decode)
  localparam int CTL_OVR = 0;
  localparam int CTL_CRC = 1;
  localparam int CTL_PAD = 2;
  localparam int CTL_BIG = 3;

  localparam int STAT_BYTES = 7;
  localparam int CNT_W      = 16;
endpackage

// File: rtl/tx_ctrl_decode.sv
module tx_ctrl_decode import txf_pkg::*; #(
  parameter int AW      = 13,
  parameter int MIN_LEN = 60,
  parameter int MAX_LEN = 1518
) (
  input  logic [3:0]    ctrl_bits,
  input  logic          g_pad,
  input  logic          g_crc,
  input  logic          g_big,
  input  logic [AW-1:0] data_len,
  output logic          eff_crc,
  output logic          too_long,
  output logic [AW-1:0] send_len
);
  logic ovr, eff_pad, eff_big;

  always_comb begin
    ovr      = ctrl_bits[CTL_OVR];
    eff_pad  = ovr ? ctrl_bits[CTL_PAD] : g_pad;
    eff_crc  = ovr ? ctrl_bits[CTL_CRC] : g_crc;
    eff_big  = ovr ? ctrl_bits[CTL_BIG] : g_big;
    too_long = (32'(data_len) > MAX_LEN) && !eff_big;
    if (too_long)
      send_len = '0;
    else if (eff_pad && (32'(data_len) < MIN_LEN))
      send_len = AW'(MIN_LEN);
    else
      send_len = data_len;
  end
endmodule

// File: rtl/tx_gap_timer.sv
module tx_gap_timer #(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [GW-1:0] load_val,
  output logic          expired
);
  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - GW'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/tx_status_byte.sv
module tx_status_byte import txf_pkg::*; #(
  parameter int AW = 13
) (
  input  logic [2:0]    sel,
  input  logic [AW-1:0] sent_len,
  input  logic          ok,
  input  logic          crc,
  output logic [7:0]    byte_o
);
  logic [CNT_W-1:0] cnt;

  always_comb begin
    cnt = CNT_W'(sent_len);
    case (sel)
      3'd0:    byte_o = cnt[7:0];
      3'd1:    byte_o = cnt[15:8];
      3'd2:    byte_o = {ok, 6'b0, crc};
      default: byte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/tx_frame_fetch.sv
module tx_frame_fetch import txf_pkg::*; #(
  parameter int AW      = 13,
  parameter int GW      = 8,
  parameter int MIN_LEN = 60,
  parameter int MAX_LEN = 1518
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_set,
  input  logic          done_clr,
  input  logic [AW-1:0] start_ptr,
  input  logic [AW-1:0] end_ptr,
  input  logic          cfg_pad_en,
  input  logic          cfg_crc_en,
  input  logic          cfg_huge_en,
  input  logic [GW-1:0] ipg_len,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [7:0]    mem_rd_data,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [7:0]    mem_wr_data,
  output logic [7:0]    out_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_last,
  output logic          out_crc_en,
  output logic          req_busy,
  output logic          done_flag,
  output logic          abort_flag
);
  localparam logic [AW-1:0] ONE  = AW'(1);
  localparam logic [AW-1:0] TWO  = AW'(2);
  localparam logic [2:0]    WLST = 3'(STAT_BYTES - 1);

  txf_state_e    state_q;
  logic          busy_q, done_q, abort_q, ok_q, crc_q;
  logic [AW-1:0] start_q, end_q, idx_q, send_q, dlen;
  logic [2:0]    widx_q;
  logic          dec_crc, dec_abort, gap_zero;
  logic [AW-1:0] dec_len;
  logic [7:0]    stat_byte;

  assign dlen = end_q - start_q;

  tx_ctrl_decode #(.AW(AW), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) dec_i (
    .ctrl_bits(mem_rd_data[3:0]), .g_pad(cfg_pad_en), .g_crc(cfg_crc_en),
    .g_big(cfg_huge_en), .data_len(dlen), .eff_crc(dec_crc),
    .too_long(dec_abort), .send_len(dec_len)
  );

  tx_gap_timer #(.GW(GW)) gap_i (
    .clk(clk), .rst(rst), .load(state_q == ST_DONE), .load_val(ipg_len),
    .expired(gap_zero)
  );

  tx_status_byte #(.AW(AW)) stat_i (
    .sel(widx_q), .sent_len(send_q), .ok(ok_q), .crc(crc_q), .byte_o(stat_byte)
  );

  // read port toward a synchronous RAM: data returns one cycle later
  always_comb begin
    mem_rd_en   = 1'b0;
    mem_rd_addr = start_q;
    case (state_q)
      ST_IDLE: mem_rd_en = busy_q && gap_zero;
      ST_CTRL: begin
        mem_rd_en   = (dec_len != '0) && (dlen != '0);
        mem_rd_addr = start_q + ONE;
      end
      ST_SEND: begin
        mem_rd_en   = out_ready && !out_last && ((idx_q + ONE) < dlen);
        mem_rd_addr = start_q + idx_q + TWO;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      abort_q    <= 1'b0;
      ok_q       <= 1'b0;
      crc_q      <= 1'b0;
      start_q    <= '0;
      end_q      <= '0;
      idx_q      <= '0;
      send_q     <= '0;
      widx_q     <= '0;
      mem_wr_en  <= 1'b0;
      mem_wr_addr<= '0;
      mem_wr_data<= '0;
      out_data   <= '0;
      out_valid  <= 1'b0;
      out_last   <= 1'b0;
      out_crc_en <= 1'b0;
    end else begin
      mem_wr_en <= 1'b0;
      if (done_clr) done_q <= 1'b0;
      if (req_set && !busy_q) begin
        busy_q  <= 1'b1;
        start_q <= start_ptr;
        end_q   <= end_ptr;
      end
      case (state_q)
        ST_IDLE: if (busy_q && gap_zero) state_q <= ST_CTRL;
        ST_CTRL: begin
          crc_q   <= dec_crc;
          send_q  <= dec_len;
          ok_q    <= !dec_abort;
          idx_q   <= '0;
          widx_q  <= '0;
          state_q <= (dec_len == '0) ? ST_STAT : ST_LOAD;
        end
        ST_LOAD: begin
          out_valid  <= 1'b1;
          out_data   <= (idx_q < dlen) ? mem_rd_data : 8'h00;
          out_last   <= (idx_q == send_q - ONE);
          out_crc_en <= crc_q;
          state_q    <= ST_SEND;
        end
        ST_SEND: if (out_ready) begin
          out_valid <= 1'b0;
          out_last  <= 1'b0;
          if (out_last) state_q <= ST_STAT;
          else begin
            idx_q   <= idx_q + ONE;
            state_q <= ST_LOAD;
          end
        end
        ST_STAT: begin
          mem_wr_en   <= 1'b1;
          mem_wr_addr <= end_q + ONE + AW'(widx_q);
          mem_wr_data <= stat_byte;
          widx_q      <= widx_q + 3'd1;
          if (widx_q == WLST) state_q <= ST_DONE;
        end
        ST_DONE: begin
          busy_q     <= 1'b0;
          done_q     <= 1'b1;
          abort_q    <= !ok_q;
          out_crc_en <= 1'b0;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_busy   = busy_q;
  assign done_flag  = done_q;
  assign abort_flag = abort_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R10
  AST_NO_STREAM_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_busy |-> !out_valid); // R2
  AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> (!req_busy && $past(req_busy))); // R2
  AST_WR_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> (req_busy && !out_valid)); // R7
  AST_GAP_RESPECTED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> gap_zero); // R9
endmodule

// File: tb/tx_frame_fetch_tb_top.sv
module tx_frame_fetch_tb_top;
  localparam int AW = 8, GW = 5, MINL = 8, MAXL = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, req_set, done_clr, cfg_pad_en, cfg_crc_en, cfg_huge_en, out_ready;
  logic [AW-1:0] start_ptr, end_ptr, mem_rd_addr, mem_wr_addr;
  logic [GW-1:0] ipg_len;
  logic mem_rd_en, mem_wr_en, out_valid, out_last, out_crc_en;
  logic req_busy, done_flag, abort_flag;
  logic [7:0] mem_rd_data, mem_wr_data, out_data;

  logic [7:0] mem [256];
  logic tb_we;
  logic [7:0] tb_wa, tb_wd;
  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
    if (tb_we) mem[tb_wa] <= tb_wd;
    if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
  end

  tx_frame_fetch #(.AW(AW), .GW(GW), .MIN_LEN(MINL), .MAX_LEN(MAXL)) dut_i (
    .clk(clk), .rst(rst), .req_set(req_set), .done_clr(done_clr),
    .start_ptr(start_ptr), .end_ptr(end_ptr), .cfg_pad_en(cfg_pad_en),
    .cfg_crc_en(cfg_crc_en), .cfg_huge_en(cfg_huge_en), .ipg_len(ipg_len),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_last(out_last), .out_crc_en(out_crc_en), .req_busy(req_busy),
    .done_flag(done_flag), .abort_flag(abort_flag)
  );

  int checks = 0, errors = 0;
  logic [7:0] lfsr = 8'h5A;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int len, input int i);
    return 8'((i * 13) + len * 3 + 5);
  endfunction

  task automatic mem_put(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_wa = a; tb_wd = d;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done_flag && cyc < 4000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_frame(input int len, input logic [7:0] ctrl, input logic gp,
                           input logic gc, input logic gb, input int gap, input int st);
    logic pad, crc, big, abrt, pv;
    logic [7:0] en, pd, eb;
    int total, cnt, cyc, bad_d, bad_l, bad_c, bad_h, bad_s;
    pad  = ctrl[0] ? ctrl[2] : gp;
    crc  = ctrl[0] ? ctrl[1] : gc;
    big  = ctrl[0] ? ctrl[3] : gb;
    abrt = (len > MAXL) && !big;
    total = abrt ? 0 : ((pad && len < MINL) ? MINL : len);
    en = 8'(st + len);
    mem_put(8'(st), ctrl);
    for (int i = 0; i < len; i++) mem_put(8'(st + 1 + i), pat(len, i));
    for (int k = 1; k <= 8; k++) mem_put(8'(en + k), 8'hEE);
    @(negedge clk);
    tb_we = 1'b0;
    cfg_pad_en = gp; cfg_crc_en = gc; cfg_huge_en = gb; ipg_len = GW'(gap);
    start_ptr = 8'(st); end_ptr = en; req_set = 1'b1; done_clr = 1'b1;
    @(negedge clk);
    req_set = 1'b0; done_clr = 1'b0;
    chk(req_busy === 1'b1, "R2 busy after request", int'(req_busy), 1);
    cnt = 0; cyc = 0; bad_d = 0; bad_l = 0; bad_c = 0; bad_h = 0; pv = 1'b0; pd = 8'h00;
    while (!done_flag && cyc < 4000) begin
      if (pv && !(out_valid && out_data == pd)) bad_h++;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = lfsr[0] | lfsr[2];
      pv = out_valid && !out_ready;
      pd = out_data;
      if (out_valid && out_ready) begin
        eb = (cnt < len) ? pat(len, cnt) : 8'h00;
        if (out_data !== eb) bad_d++;
        if (out_last !== (cnt == total - 1)) bad_l++;
        if (out_crc_en !== crc) bad_c++;
        cnt++;
      end
      @(negedge clk);
      cyc++;
    end
    out_ready = 1'b0;
    chk(cyc < 4000, "R2 frame completes", cyc, 4000);
    chk(req_busy === 1'b0, "R2 busy clears with done", int'(req_busy), 0);
    chk(cnt == total, "R4 R5 R11 streamed byte count", cnt, total);
    chk(bad_d == 0, "R3 R5 data bytes", bad_d, 0);
    chk(bad_l == 0, "R3 last marker", bad_l, 0);
    chk(bad_c == 0, "R4 R8 crc sideband", bad_c, 0);
    chk(bad_h == 0, "R10 hold under backpressure", bad_h, 0);
    chk(abort_flag === abrt, "R6 abort flag", int'(abort_flag), int'(abrt));
    bad_s = 0;
    for (int k = 0; k < 7; k++) begin
      case (k)
        0: eb = 8'(total);
        1: eb = 8'(total >> 8);
        2: eb = {~abrt, 6'b0, crc};
        default: eb = 8'h00;
      endcase
      if (mem[8'(en + 1 + k)] !== eb) bad_s++;
    end
    if (mem[8'(en + 8)] !== 8'hEE) bad_s++;
    chk(bad_s == 0, "R7 R11 status record", bad_s, 0);
  endtask

  task automatic b2b(input int g);
    int cyc, k;
    mem_put(8'h40, 8'h00);
    for (int i = 0; i < 5; i++) mem_put(8'(8'h41 + i), pat(5, i));
    @(negedge clk);
    tb_we = 1'b0; out_ready = 1'b1;
    cfg_pad_en = 1'b0; cfg_crc_en = 1'b0; cfg_huge_en = 1'b0; ipg_len = GW'(g);
    start_ptr = 8'h40; end_ptr = 8'h45; req_set = 1'b1; done_clr = 1'b1;
    @(negedge clk);
    req_set = 1'b0; done_clr = 1'b0;
    wait_done(cyc);
    req_set = 1'b1; done_clr = 1'b1;
    @(negedge clk);
    req_set = 1'b0; done_clr = 1'b0;
    k = 1;
    while (!out_valid && k < 200) begin
      @(negedge clk);
      k++;
    end
    chk(k >= g + 3 && k <= g + 4, "R9 gap before next frame", k, g + 3);
    wait_done(cyc);
    chk(cyc < 4000 && abort_flag === 1'b0, "R9 second frame completes", cyc, 0);
    out_ready = 1'b0;
  endtask

  task automatic main_seq();
    logic [7:0] ctl [5];
    logic gpv [5], gcv [5], gbv [5];
    ctl[0] = 8'h00; gpv[0] = 1; gcv[0] = 1; gbv[0] = 0;
    ctl[1] = 8'h00; gpv[1] = 0; gcv[1] = 0; gbv[1] = 0;
    ctl[2] = 8'h0B; gpv[2] = 1; gcv[2] = 0; gbv[2] = 0;
    ctl[3] = 8'h00; gpv[3] = 0; gcv[3] = 1; gbv[3] = 1;
    ctl[4] = 8'h05; gpv[4] = 0; gcv[4] = 1; gbv[4] = 1;
    rst = 1'b1; req_set = 0; done_clr = 0; out_ready = 0; tb_we = 0; tb_wa = 0; tb_wd = 0;
    cfg_pad_en = 0; cfg_crc_en = 0; cfg_huge_en = 0; ipg_len = '0;
    start_ptr = '0; end_ptr = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({req_busy, done_flag, abort_flag, out_valid, mem_wr_en} === 5'b0,
        "R1 reset state", int'({req_busy, done_flag, abort_flag, out_valid, mem_wr_en}), 0);
    for (int c = 0; c < 5; c++)
      for (int len = 0; len <= 24; len++)
        run_frame(len, ctl[c], gpv[c], gcv[c], gbv[c], (len % 3) * 2,
                  (len * 37 + c * 11 + 232) % 256);
    b2b(0);
    b2b(1);
    b2b(6);
    b2b(20);
  endtask

  initial begin
    bit wd_fired;
    wd_fired = 1'b0;
    fork
      main_seq();
      begin
        repeat (150000) @(posedge clk);
        wd_fired = 1'b1;
      end
    join_any
    disable fork;
    if (wd_fired) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired actual=150000 expected=0");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule